// File: doc/BRIEF.md
# Output Neuron Ranking Unit

This block sits behind the output layer of a perceptron and turns that layer's activations into a ranked list of classes. Each cycle it can accept one activation together with the class index it belongs to. Every accepted value is placed at once into a register array that is kept sorted at all times. When the configured number of activations has arrived, the array already holds the complete ranking, from the highest activation down to the lowest.

The top entry of the array is exposed as a winner-take-all result, and it is valid together with a completion flag. The complete ordering is read out one class index per read strobe, starting from the highest-ranked class. A start pulse clears the unit before a new pattern. The number of active outputs is taken from a port, so one instance can serve network topologies of different sizes without being rebuilt.

Top module: `rank_top`

## Requirements
- R1: After reset, `done` and `rd_valid` are low and `win_idx` reads 0.
- R2: `win_idx` always holds the index of the stored entry with the largest activation, with ties going to the lower index. When an accepted input becomes the new maximum, `win_idx` shows it in the cycle right after the edge that captured it.
- R3: Activations are compared as unsigned numbers under the default configuration. The readout lists the classes in non-increasing order of activation.
- R4: Entries with equal activation come out in ascending order of class index.
- R5: `done` is low while fewer than `cfg_count` values have been accepted. It rises in the cycle right after the clock edge that captures the `cfg_count`-th value, so no cycles are spent sorting after the last input.
- R6: Inputs offered while `done` is high are discarded. Neither the winner nor the readout content changes.
- R7: A read strobe sampled on a clock edge gives `rd_valid` high in the following cycle, with the next index on `rd_idx`. The first read returns the top entry, and strobes on consecutive cycles step through the list one entry per cycle.
- R8: A read at a position at or beyond `cfg_count` returns the all-ones index (63 for the default 64 outputs).
- R9: `start` empties the array, zeroes the input count and rewinds the read position. A value offered in the same cycle as `start` is dropped.
- R10: `cfg_count` may take any value from 1 to the output limit, 64 by default, and the ranking covers exactly that many classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the unit before a new pattern |
| cfg_count | input | 7 | Number of active outputs, 1 to 64 |
| in_valid | input | 1 | An activation is offered this cycle |
| in_val | input | 16 | Activation value |
| in_idx | input | 6 | Class index of the activation |
| done | output | 1 | All configured activations received |
| win_idx | output | 6 | Index of the highest activation so far |
| win_val | output | 16 | Highest activation so far |
| rd_strobe | input | 1 | Request the next ranked index |
| rd_idx | output | 6 | Ranked index returned by a read |
| rd_valid | output | 1 | `rd_idx` holds the answer to the previous strobe |

## Verification
The capture of the final activation and the completion of the ranking fall in the same cycle. The edge that stores the last value must raise `done` and, if that value is the largest, must also move it into the winner position. The bench provokes this by sending the largest activation of a pattern last. One cycle before that edge it checks that `done` is still low, and one cycle after it checks that `done` is high and that `win_idx` names the late arrival. A second collision is provoked by asserting `start` together with a valid input, and the bench then confirms that the dropped value never appears in the readout.

// File: rtl/rank_pkg.sv
package rank_pkg;

   // width needed to encode n distinct values (at least one bit)
   function automatic int unsigned enc_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rank_cell.sv
// One slot of the sorted array: decides whether a new value belongs at or
// above this position and shifts or loads accordingly.
module rank_cell #(
   parameter int VAL_W      = 16,
   parameter int IDX_W      = 6,
   parameter bit SIGNED_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [VAL_W-1:0] new_val,
   input  logic [IDX_W-1:0] new_idx,
   input  logic             up_ins,
   input  logic             up_occ,
   input  logic [VAL_W-1:0] up_val,
   input  logic [IDX_W-1:0] up_idx,
   output logic             ins,
   output logic             occ,
   output logic [VAL_W-1:0] val,
   output logic [IDX_W-1:0] idx
);

   logic gt;

   generate
      if (SIGNED_VAL) begin : g_signed
         assign gt = $signed(new_val) > $signed(val);
      end else begin : g_unsigned
         assign gt = new_val > val;
      end
   endgenerate

   // new entry ranks at or above this slot
   assign ins = !occ || gt || ((new_val == val) && (new_idx < idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ <= 1'b0;
         val <= '0;
         idx <= '0;
      end else if (clr) begin
         occ <= 1'b0;
      end else if (load && ins) begin
         if (up_ins) begin
            occ <= up_occ;
            val <= up_val;
            idx <= up_idx;
         end else begin
            occ <= 1'b1;
            val <= new_val;
            idx <= new_idx;
         end
      end
   end

endmodule

// File: rtl/rank_count.sv
// Counts accepted activations and flags completion.
module rank_count #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             in_valid,
   input  logic [CNT_W-1:0] limit,
   output logic             load,
   output logic             done,
   output logic [CNT_W-1:0] cnt
);

   assign done = (cnt == limit);
   assign load = in_valid && !clr && !done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (load) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/rank_readout.sv
// Sequential readout of the ranked indices, top first.
module rank_readout #(
   parameter int N_OUT = 64,
   parameter int IDX_W = 6,
   parameter int CNT_W = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   rd_strobe,
   input  logic [CNT_W-1:0]       limit,
   input  logic [N_OUT*IDX_W-1:0] idx_flat,
   output logic [IDX_W-1:0]       rd_idx,
   output logic                   rd_valid,
   output logic [CNT_W-1:0]       rd_ptr
);

   localparam logic [CNT_W-1:0] PTR_END = CNT_W'(N_OUT);

   logic [IDX_W-1:0] ptr_lo;
   logic [IDX_W-1:0] sel;

   assign ptr_lo = rd_ptr[IDX_W-1:0];

   always_comb begin
      sel = '1;
      for (int k = 0; k < N_OUT; k++) begin
         if (ptr_lo == IDX_W'(k)) sel = idx_flat[k*IDX_W +: IDX_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr   <= '0;
         rd_idx   <= '0;
         rd_valid <= 1'b0;
      end else if (clr) begin
         rd_ptr   <= '0;
         rd_idx   <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_strobe;
         if (rd_strobe) begin
            rd_idx <= (rd_ptr < limit) ? sel : '1;
            if (rd_ptr < PTR_END) rd_ptr <= rd_ptr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rank_top.sv
module rank_top #(
   parameter int N_OUT      = 64,
   parameter int VAL_W      = 16,
   parameter bit SIGNED_VAL = 1'b0,
   localparam int IDX_W     = rank_pkg::enc_bits(N_OUT),
   localparam int CNT_W     = rank_pkg::enc_bits(N_OUT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic             in_valid,
   input  logic [VAL_W-1:0] in_val,
   input  logic [IDX_W-1:0] in_idx,
   output logic             done,
   output logic [IDX_W-1:0] win_idx,
   output logic [VAL_W-1:0] win_val,
   input  logic             rd_strobe,
   output logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid
);

   generate
      if (N_OUT < 2) begin : g_bad_n
         $error("rank_top: N_OUT must be at least 2");
      end
      if (VAL_W < 1) begin : g_bad_w
         $error("rank_top: VAL_W must be at least 1");
      end
   endgenerate

   localparam logic [CNT_W-1:0] N_LIM = CNT_W'(N_OUT);

   logic [CNT_W-1:0]       cfg_eff;
   logic                   load;
   logic [CNT_W-1:0]       cnt_q;
   logic [CNT_W-1:0]       rd_ptr;
   logic [N_OUT-1:0]       slot_occ;
   logic [N_OUT-1:0]       slot_ins;
   logic [N_OUT*VAL_W-1:0] slot_val_flat;
   logic [N_OUT*IDX_W-1:0] slot_idx_flat;

   // keep the active count inside 1..N_OUT
   assign cfg_eff = (cfg_count == '0)  ? CNT_W'(1) :
                    (cfg_count > N_LIM) ? N_LIM     : cfg_count;

   rank_count #(.CNT_W(CNT_W)) i_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .in_valid (in_valid),
      .limit    (cfg_eff),
      .load     (load),
      .done     (done),
      .cnt      (cnt_q)
   );

   generate
      for (genvar k = 0; k < N_OUT; k++) begin : g_slot
         logic             u_ins;
         logic             u_occ;
         logic [VAL_W-1:0] u_val;
         logic [IDX_W-1:0] u_idx;
         if (k == 0) begin : g_head
            assign u_ins = 1'b0;
            assign u_occ = 1'b0;
            assign u_val = '0;
            assign u_idx = '0;
         end else begin : g_body
            assign u_ins = slot_ins[k-1];
            assign u_occ = slot_occ[k-1];
            assign u_val = slot_val_flat[(k-1)*VAL_W +: VAL_W];
            assign u_idx = slot_idx_flat[(k-1)*IDX_W +: IDX_W];
         end
         rank_cell #(
            .VAL_W      (VAL_W),
            .IDX_W      (IDX_W),
            .SIGNED_VAL (SIGNED_VAL)
         ) i_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (start),
            .load    (load),
            .new_val (in_val),
            .new_idx (in_idx),
            .up_ins  (u_ins),
            .up_occ  (u_occ),
            .up_val  (u_val),
            .up_idx  (u_idx),
            .ins     (slot_ins[k]),
            .occ     (slot_occ[k]),
            .val     (slot_val_flat[k*VAL_W +: VAL_W]),
            .idx     (slot_idx_flat[k*IDX_W +: IDX_W])
         );
      end
   endgenerate

   assign win_idx = slot_idx_flat[IDX_W-1:0];
   assign win_val = slot_val_flat[VAL_W-1:0];

   rank_readout #(
      .N_OUT (N_OUT),
      .IDX_W (IDX_W),
      .CNT_W (CNT_W)
   ) i_readout (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start),
      .rd_strobe (rd_strobe),
      .limit     (cfg_eff),
      .idx_flat  (slot_idx_flat),
      .rd_idx    (rd_idx),
      .rd_valid  (rd_valid),
      .rd_ptr    (rd_ptr)
   );

endmodule

// File: rtl/rank_chk.sv
module rank_chk #(
   parameter int N_OUT      = 64,
   parameter int VAL_W      = 16,
   parameter bit SIGNED_VAL = 1'b0,
   parameter int IDX_W      = 6,
   parameter int CNT_W      = 7
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   start,
   input logic                   in_valid,
   input logic [VAL_W-1:0]       in_val,
   input logic [IDX_W-1:0]       in_idx,
   input logic                   done,
   input logic [IDX_W-1:0]       win_idx,
   input logic                   rd_strobe,
   input logic [IDX_W-1:0]       rd_idx,
   input logic                   rd_valid,
   input logic                   load,
   input logic [CNT_W-1:0]       cnt,
   input logic [CNT_W-1:0]       cfg,
   input logic [CNT_W-1:0]       rd_ptr,
   input logic [N_OUT-1:0]       occ,
   input logic [N_OUT*VAL_W-1:0] vals,
   input logic [N_OUT*IDX_W-1:0] idxs
);

   logic [VAL_W-1:0] top_val;
   assign top_val = vals[VAL_W-1:0];

   // R2
   new_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !SIGNED_VAL && (!occ[0] || in_val > top_val)) |=> (win_idx == $past(in_idx)));

   // R5
   done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (cnt + 1'b1 == cfg)) |=> (done || (cfg != $past(cfg))));

   // R6
   frozen_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && in_valid && !start) |=> ($stable(vals) && $stable(idxs) && $stable(occ)));

   // R7
   read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !start) |=> rd_valid);

   // R7
   no_spurious_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> !rd_valid);

   // R8
   beyond_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !start && (rd_ptr >= cfg)) |=> (rd_idx == '1));

   // R9
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!occ[0] && (cnt == '0) && (rd_ptr == '0)));

   generate
      for (genvar k = 0; k + 1 < N_OUT; k++) begin : g_pair
         logic [VAL_W-1:0] va;
         logic [VAL_W-1:0] vb;
         logic [IDX_W-1:0] ia;
         logic [IDX_W-1:0] ib;
         logic             ge;
         assign va = vals[k*VAL_W +: VAL_W];
         assign vb = vals[(k+1)*VAL_W +: VAL_W];
         assign ia = idxs[k*IDX_W +: IDX_W];
         assign ib = idxs[(k+1)*IDX_W +: IDX_W];
         if (SIGNED_VAL) begin : g_s
            assign ge = $signed(va) >= $signed(vb);
         end else begin : g_u
            assign ge = va >= vb;
         end
         // R3
         order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            occ[k+1] |-> (occ[k] && ge));
         // R4
         tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (occ[k+1] && (va == vb)) |-> (ia < ib));
      end
   endgenerate

endmodule

bind rank_top rank_chk #(
   .N_OUT      (N_OUT),
   .VAL_W      (VAL_W),
   .SIGNED_VAL (SIGNED_VAL),
   .IDX_W      (IDX_W),
   .CNT_W      (CNT_W)
) i_rank_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .in_valid  (in_valid),
   .in_val    (in_val),
   .in_idx    (in_idx),
   .done      (done),
   .win_idx   (win_idx),
   .rd_strobe (rd_strobe),
   .rd_idx    (rd_idx),
   .rd_valid  (rd_valid),
   .load      (load),
   .cnt       (cnt_q),
   .cfg       (cfg_eff),
   .rd_ptr    (rd_ptr),
   .occ       (slot_occ),
   .vals      (slot_val_flat),
   .idxs      (slot_idx_flat)
);

// File: tb/test_rank_top.sv
module test_rank_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [6:0]  cfg_count = 7'd1;
   logic        in_valid = 1'b0;
   logic [15:0] in_val = '0;
   logic [5:0]  in_idx = '0;
   logic        done;
   logic [5:0]  win_idx;
   logic [15:0] win_val;
   logic        rd_strobe = 1'b0;
   logic [5:0]  rd_idx;
   logic        rd_valid;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   int    bv [64];
   int    bi [64];
   int    exp_q [$];
   string tag_q [$];

   always #5 clk = ~clk;

   rank_top i_rank_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cfg_count (cfg_count),
      .in_valid  (in_valid),
      .in_val    (in_val),
      .in_idx    (in_idx),
      .done      (done),
      .win_idx   (win_idx),
      .win_val   (win_val),
      .rd_strobe (rd_strobe),
      .rd_idx    (rd_idx),
      .rd_valid  (rd_valid)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected read response", int'(rd_idx), -1);
         end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(int'(rd_idx) == e, t, int'(rd_idx), e);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(1'b0, "watchdog expired", cycles, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // bench ranking model: highest value first, ties by lower index
   task automatic push_ranking(input int n, input int extra);
      bit used [64];
      for (int k = 0; k < 64; k++) used[k] = 1'b0;
      for (int r = 0; r < n; r++) begin
         int best = -1;
         for (int j = 0; j < n; j++) begin
            if (!used[j]) begin
               if (best < 0 || bv[j] > bv[best] ||
                   (bv[j] == bv[best] && bi[j] < bi[best])) best = j;
            end
         end
         used[best] = 1'b1;
         exp_q.push_back(bi[best]);
         tag_q.push_back(r == 0 ? "R7 first read is top" : "R3/R4 ranked order");
      end
      for (int x = 0; x < extra; x++) begin
         exp_q.push_back(63);
         tag_q.push_back("R8 read beyond count");
      end
   endtask

   function automatic int top_index(input int n);
      int best = 0;
      for (int j = 1; j < n; j++)
         if (bv[j] > bv[best] || (bv[j] == bv[best] && bi[j] < bi[best])) best = j;
      return bi[best];
   endfunction

   // start, stream n values, optional junk with start, optional late inputs
   task automatic run_case(input int n, input bit junk_with_start, input int late, input int extra);
      int wexp;
      @(negedge clk);
      cfg_count = 7'(n);
      start = 1'b1;
      if (junk_with_start) begin
         in_valid = 1'b1;
         in_val   = 16'hFFFF;
         in_idx   = 6'd5;
      end
      @(negedge clk);
      start = 1'b0;
      in_valid = 1'b0;
      check(done == 1'b0, "R9 done low after start", int'(done), 0);
      for (int j = 0; j < n; j++) begin
         if (j == n - 1) check(done == 1'b0, "R5 done low before last value", int'(done), 0);
         in_valid = 1'b1;
         in_val   = 16'(bv[j]);
         in_idx   = 6'(bi[j]);
         @(negedge clk);
      end
      in_valid = 1'b0;
      wexp = top_index(n);
      check(done == 1'b1, "R5 done right after last value", int'(done), 1);
      check(int'(win_idx) == wexp, "R2 winner with done", int'(win_idx), wexp);
      for (int j = 0; j < late; j++) begin
         in_valid = 1'b1;
         in_val   = 16'hFFFF;
         in_idx   = 6'(60 - j);
         @(negedge clk);
      end
      in_valid = 1'b0;
      if (late > 0) begin
         @(negedge clk);
         check(int'(win_idx) == wexp, "R6 winner kept after late inputs", int'(win_idx), wexp);
         check(done == 1'b1, "R6 done kept", int'(done), 1);
      end
      push_ranking(n, extra);
      for (int r = 0; r < n + extra; r++) begin
         rd_strobe = 1'b1;
         @(negedge clk);
      end
      rd_strobe = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, "R7 all reads answered", exp_q.size(), 0);
   endtask

   initial begin
      int lfsr;
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1 done low in reset", int'(done), 0);
      check(rd_valid == 1'b0, "R1 rd_valid low in reset", int'(rd_valid), 0);
      check(win_idx == 6'd0, "R1 winner index zero", int'(win_idx), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // case A: ties, largest value last, late inputs ignored (R2 R4 R5 R6 R8)
      bv[0] = 10;  bi[0] = 3;
      bv[1] = 30;  bi[1] = 9;
      bv[2] = 30;  bi[2] = 1;
      bv[3] = 5;   bi[3] = 4;
      bv[4] = 0;   bi[4] = 0;
      bv[5] = 7;   bi[5] = 2;
      bv[6] = 30;  bi[6] = 12;
      bv[7] = 200; bi[7] = 7;
      run_case(8, 1'b0, 3, 2);

      // case B: full 64 outputs, heavy ties (R3 R4 R10)
      lfsr = 16'hACE1;
      for (int j = 0; j < 64; j++) begin
         lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0)) & 16'hFFFF;
         bv[j] = lfsr & 7;
         bi[j] = (j * 37) % 64;
      end
      run_case(64, 1'b0, 0, 1);

      // case C: single output, junk offered with start is dropped (R9 R10)
      bv[0] = 42; bi[0] = 63;
      run_case(1, 1'b1, 0, 2);

      // case D: descending stream (R3 R10)
      for (int j = 0; j < 16; j++) begin
         bv[j] = 1000 - j * 10;
         bi[j] = j;
      end
      run_case(16, 1'b0, 0, 1);

      // case E: ascending stream, every input a new winner (R2 R3)
      for (int j = 0; j < 16; j++) begin
         bv[j] = 100 + j * 3;
         bi[j] = 40 + j;
      end
      run_case(16, 1'b0, 1, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule